// File: doc/BRIEF.md
# Indexed Endpoint Register Bank for a USB Function Controller

This block is the CPU-side register file of a USB function controller. A byte-wide CPU bus reaches a global control register, an endpoint index register and a window of per-endpoint registers: IN and OUT control/status, IN and OUT maximum packet size, and the OUT received-byte count. Which endpoint that window shows depends on the current index value. Each endpoint's FIFO data port has its own fixed address and does not depend on the index.

The status bits follow bit-level access rules. The CPU can only set the IN "packet loaded" bit, and hardware clears it. Hardware sets the OUT "packet received" bit, and the CPU can only clear it. The control register keeps its value across a USB bus reset. All other state returns to its default on a bus reset. When the CPU turns the controller on, the block enforces a short settling window. For that window it refuses every access except to the control register.

Address map (4-bit address): 0x0 control, 0x1 index, 0x2 IN status, 0x3 OUT status, 0x4 IN max packet, 0x5 OUT max packet, 0x6 OUT byte count, 0x8+n FIFO port of endpoint n. All other addresses read zero. Reads are combinational while `cpu_rd` is high, and `cpu_rdata` is zero while it is low. Writes take effect on the clock edge where `cpu_wr` is high.

Top module: `usb_epreg_bank`

## Requirements
- R1: The index register (0x1) holds 3 bits taken from write data bits 2:0 and reads back with bits 7:3 zero. Its value selects the endpoint whose IN status, OUT status, IN max packet, OUT max packet and OUT byte count appear at 0x2 to 0x6.
- R2: An index value of NUM_EP (5) or above selects no endpoint. Reads of 0x2 to 0x6 then return zero, and writes to them change no endpoint's state.
- R3: Address 0x8+n is the FIFO port of endpoint n regardless of the index. A write there pulses `fifo_wr[n]` combinationally, and a read pulses `fifo_rd[n]` and returns byte n of `fifo_rdata`.
- R4: IN status bit 0 (packet loaded, output `in_rdy[n]`) is set by a CPU write of 1, is unchanged by a CPU write of 0, and is cleared by an `ep_in_sent[n]` pulse. Bits 7:1 are plain read/write.
- R5: OUT status bit 0 (packet received, output `out_rdy[n]`) is set by an `ep_out_rcvd[n]` pulse, is cleared by a CPU write of 0, and is unchanged by a CPU write of 1. Bits 7:1 are plain read/write.
- R6: When a hardware event and a CPU write on the same bit 0 land on the same edge, the hardware event wins.
- R7: The OUT byte count (0x6) is read-only. It reads byte n of `ep_out_count` for the selected endpoint, and writes to it have no effect.
- R8: The control register (0x0) is read/write, and its bit 7 drives `usb_en`. A bus reset leaves it unchanged, and only `rst_n` clears it.
- R9: A `bus_rst` pulse clears the index, both status registers and both max-packet registers of every endpoint.
- R10: A control write that takes bit 7 from 0 to 1 on edge k holds `reg_busy` high after edges k to k+LOCK_CYC-1 (default 3). Writes on edges k+1 to k+LOCK_CYC to any address other than 0x0 are ignored. While busy, reads of any address other than 0x0 return zero and no FIFO strobe fires. Writing 1 to an already-set bit 7 does not restart the window.
- R11: Both max-packet registers are 8-bit read/write and are kept separately for each endpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| bus_rst | input | 1 | USB bus reset pulse, synchronous |
| cpu_addr | input | 4 | CPU register address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |
| ep_in_sent | input | NUM_EP | Per endpoint: IN packet sent, clears in_rdy |
| ep_out_rcvd | input | NUM_EP | Per endpoint: OUT packet received, sets out_rdy |
| ep_out_count | input | NUM_EP*8 | Per endpoint OUT byte count, byte n for endpoint n |
| fifo_rdata | input | NUM_EP*8 | Per endpoint FIFO read byte |
| fifo_wr | output | NUM_EP | FIFO write strobe per endpoint |
| fifo_rd | output | NUM_EP | FIFO read strobe per endpoint |
| usb_en | output | 1 | Controller enable (control bit 7) |
| reg_busy | output | 1 | Post-enable access lockout active |
| in_rdy | output | NUM_EP | IN packet loaded flag per endpoint |
| out_rdy | output | NUM_EP | OUT packet received flag per endpoint |

## Verification
A vector table first writes distinct max-packet values to two endpoints and then switches the index between them. A wrong read-back shows whether the window follows the index or leaks state from another endpoint. The same table writes all-ones and all-zeros patterns to both status registers, which separates the set-only bit from the clear-only bit and both from the plain bits. Out-of-range index values 7 and 5 are followed by writes and reads that must leave endpoint 1 intact. Directed sequences then place hardware events on the same edge as CPU writes, issue bus resets with the controller off and on, and step access attempts through every edge of the enable window. That last step shows whether the window is too short or too long.

// File: rtl/usb_reg_pkg.sv
package usb_reg_pkg;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int IDX_W = 3;
  localparam int EN_BIT = 7;

  localparam logic [AW-1:0] A_CTRL    = 4'h0;
  localparam logic [AW-1:0] A_INDEX   = 4'h1;
  localparam logic [AW-1:0] A_INCSR   = 4'h2;
  localparam logic [AW-1:0] A_OUTCSR  = 4'h3;
  localparam logic [AW-1:0] A_INMAXP  = 4'h4;
  localparam logic [AW-1:0] A_OUTMAXP = 4'h5;
  localparam logic [AW-1:0] A_WCNT    = 4'h6;
  localparam logic [AW-1:0] A_FIFO0   = 4'h8;

  // IN status: bit 0 may only be set by the CPU
  function automatic logic [DW-1:0] in_csr_wr(input logic old0, input logic [DW-1:0] wd);
    return {wd[DW-1:1], old0 | wd[0]};
  endfunction

  // OUT status: bit 0 may only be cleared by the CPU
  function automatic logic [DW-1:0] out_csr_wr(input logic old0, input logic [DW-1:0] wd);
    return {wd[DW-1:1], old0 & wd[0]};
  endfunction

  function automatic logic en_rise(input logic old_en, input logic new_en);
    return !old_en && new_en;
  endfunction
endpackage

// File: rtl/usb_lock_timer.sv
module usb_lock_timer #(
  parameter int LOCK_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(LOCK_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (start)      cnt_q <= CW'(LOCK_CYC);
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/usb_ep_slice.sv
module usb_ep_slice
  import usb_reg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rst,
  input  logic [DW-1:0] wdata,
  input  logic          wr_incsr,
  input  logic          wr_outcsr,
  input  logic          wr_inmaxp,
  input  logic          wr_outmaxp,
  input  logic          in_sent,
  input  logic          out_rcvd,
  output logic [DW-1:0] in_csr,
  output logic [DW-1:0] out_csr,
  output logic [DW-1:0] in_maxp,
  output logic [DW-1:0] out_maxp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_csr <= '0; out_csr <= '0; in_maxp <= '0; out_maxp <= '0;
    end else if (bus_rst) begin
      in_csr <= '0; out_csr <= '0; in_maxp <= '0; out_maxp <= '0;
    end else begin
      if (wr_incsr)   in_csr   <= in_csr_wr(in_csr[0], wdata);
      if (in_sent)    in_csr[0] <= 1'b0;   // hardware wins over CPU set
      if (wr_outcsr)  out_csr  <= out_csr_wr(out_csr[0], wdata);
      if (out_rcvd)   out_csr[0] <= 1'b1;  // hardware wins over CPU clear
      if (wr_inmaxp)  in_maxp  <= wdata;
      if (wr_outmaxp) out_maxp <= wdata;
    end
  end
endmodule

// File: rtl/usb_epreg_bank.sv
module usb_epreg_bank
  import usb_reg_pkg::*;
#(
  parameter int NUM_EP   = 5,
  parameter int LOCK_CYC = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_rst,
  input  logic [AW-1:0]        cpu_addr,
  input  logic                 cpu_wr,
  input  logic                 cpu_rd,
  input  logic [DW-1:0]        cpu_wdata,
  output logic [DW-1:0]        cpu_rdata,
  input  logic [NUM_EP-1:0]    ep_in_sent,
  input  logic [NUM_EP-1:0]    ep_out_rcvd,
  input  logic [NUM_EP*DW-1:0] ep_out_count,
  input  logic [NUM_EP*DW-1:0] fifo_rdata,
  output logic [NUM_EP-1:0]    fifo_wr,
  output logic [NUM_EP-1:0]    fifo_rd,
  output logic                 usb_en,
  output logic                 reg_busy,
  output logic [NUM_EP-1:0]    in_rdy,
  output logic [NUM_EP-1:0]    out_rdy
);
  logic [DW-1:0]    ctrl_q;
  logic [IDX_W-1:0] idx_q;

  // named events for the checker
  logic ctl_wr, enable_rise, wr_ok, idx_valid;
  logic [NUM_EP-1:0] ep_sel, fifo_hit;

  logic [DW-1:0] in_csr_a  [NUM_EP];
  logic [DW-1:0] out_csr_a [NUM_EP];
  logic [DW-1:0] in_mx_a   [NUM_EP];
  logic [DW-1:0] out_mx_a  [NUM_EP];

  assign ctl_wr      = cpu_wr && (cpu_addr == A_CTRL);
  assign enable_rise = ctl_wr && en_rise(ctrl_q[EN_BIT], cpu_wdata[EN_BIT]);
  assign wr_ok       = cpu_wr && !reg_busy;
  assign idx_valid   = int'(idx_q) < NUM_EP;
  assign usb_en      = ctrl_q[EN_BIT];

  // control register: system reset only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (ctl_wr) ctrl_q <= cpu_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (bus_rst) idx_q <= '0;
    else if (wr_ok && cpu_addr == A_INDEX) idx_q <= cpu_wdata[IDX_W-1:0];
  end

  usb_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk   (clk),
    .rst_n (rst_n),
    .start (enable_rise),
    .busy  (reg_busy)
  );

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    assign ep_sel[e]   = idx_valid && (idx_q == IDX_W'(e));
    assign fifo_hit[e] = (cpu_addr == AW'(int'(A_FIFO0) + e));
    assign fifo_wr[e]  = cpu_wr && !reg_busy && fifo_hit[e];
    assign fifo_rd[e]  = cpu_rd && !reg_busy && fifo_hit[e];

    usb_ep_slice u_slice (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_rst    (bus_rst),
      .wdata      (cpu_wdata),
      .wr_incsr   (wr_ok && ep_sel[e] && cpu_addr == A_INCSR),
      .wr_outcsr  (wr_ok && ep_sel[e] && cpu_addr == A_OUTCSR),
      .wr_inmaxp  (wr_ok && ep_sel[e] && cpu_addr == A_INMAXP),
      .wr_outmaxp (wr_ok && ep_sel[e] && cpu_addr == A_OUTMAXP),
      .in_sent    (ep_in_sent[e]),
      .out_rcvd   (ep_out_rcvd[e]),
      .in_csr     (in_csr_a[e]),
      .out_csr    (out_csr_a[e]),
      .in_maxp    (in_mx_a[e]),
      .out_maxp   (out_mx_a[e])
    );

    assign in_rdy[e]  = in_csr_a[e][0];
    assign out_rdy[e] = out_csr_a[e][0];
  end

  // read path
  logic [DW-1:0] rd_val, w_incsr, w_outcsr, w_inmx, w_outmx, w_cnt;

  always_comb begin
    w_incsr = '0; w_outcsr = '0; w_inmx = '0; w_outmx = '0; w_cnt = '0;
    for (int e = 0; e < NUM_EP; e++) begin
      if (ep_sel[e]) begin
        w_incsr  = in_csr_a[e];
        w_outcsr = out_csr_a[e];
        w_inmx   = in_mx_a[e];
        w_outmx  = out_mx_a[e];
        w_cnt    = ep_out_count[e*DW +: DW];
      end
    end
    rd_val = '0;
    case (cpu_addr)
      A_CTRL:    rd_val = ctrl_q;
      A_INDEX:   rd_val = DW'(idx_q);
      A_INCSR:   rd_val = w_incsr;
      A_OUTCSR:  rd_val = w_outcsr;
      A_INMAXP:  rd_val = w_inmx;
      A_OUTMAXP: rd_val = w_outmx;
      A_WCNT:    rd_val = w_cnt;
      default:   rd_val = '0;
    endcase
    for (int e = 0; e < NUM_EP; e++) begin
      if (fifo_hit[e]) rd_val = fifo_rdata[e*DW +: DW];
    end
  end

  assign cpu_rdata = (!cpu_rd || (reg_busy && cpu_addr != A_CTRL)) ? '0 : rd_val;
endmodule

// File: rtl/usb_reg_checker.sv
module usb_reg_checker
  import usb_reg_pkg::*;
#(
  parameter int NUM_EP   = 5,
  parameter int LOCK_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rst,
  input logic [AW-1:0]     cpu_addr,
  input logic              cpu_rd,
  input logic [DW-1:0]     cpu_rdata,
  input logic [NUM_EP-1:0] ep_out_rcvd,
  input logic [NUM_EP-1:0] fifo_wr,
  input logic [NUM_EP-1:0] fifo_rd,
  input logic              usb_en,
  input logic              reg_busy,
  input logic [NUM_EP-1:0] in_rdy,
  input logic [NUM_EP-1:0] out_rdy,
  input logic              ctl_wr,
  input logic              enable_rise
);
  localparam int RW = $clog2(LOCK_CYC + 2);
  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_cnt <= '0;
    else if (reg_busy) run_cnt <= run_cnt + 1'b1;
    else               run_cnt <= '0;
  end

  a_r10_busy_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
    enable_rise |=> reg_busy);

  a_r10_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    reg_busy |-> (run_cnt < RW'(LOCK_CYC)));

  a_r10_read_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_busy && cpu_rd && cpu_addr != A_CTRL) |-> (cpu_rdata == '0));

  a_r10_no_fifo_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    reg_busy |-> (fifo_wr == '0 && fifo_rd == '0));

  a_r3_fifo_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fifo_wr) && $onehot0(fifo_rd));

  a_r8_ctrl_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst && !ctl_wr) |=> $stable(usb_en));

  a_r9_bus_rst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (in_rdy == '0 && out_rdy == '0));

  a_r5_out_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    (out_rdy & ~$past(out_rdy) & ~$past(ep_out_rcvd)) == '0);
endmodule

bind usb_epreg_bank usb_reg_checker #(.NUM_EP(NUM_EP), .LOCK_CYC(LOCK_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_rst     (bus_rst),
  .cpu_addr    (cpu_addr),
  .cpu_rd      (cpu_rd),
  .cpu_rdata   (cpu_rdata),
  .ep_out_rcvd (ep_out_rcvd),
  .fifo_wr     (fifo_wr),
  .fifo_rd     (fifo_rd),
  .usb_en      (usb_en),
  .reg_busy    (reg_busy),
  .in_rdy      (in_rdy),
  .out_rdy     (out_rdy),
  .ctl_wr      (ctl_wr),
  .enable_rise (enable_rise)
);

// File: tb/tb_usb_epreg_bank.sv
`timescale 1ns/1ps
module tb_usb_epreg_bank;
  localparam int NEP = 5;
  localparam logic [3:0] CTRL = 4'h0, IDX = 4'h1, INCSR = 4'h2, OUTCSR = 4'h3,
                         INMX = 4'h4, OUTMX = 4'h5, WCNT = 4'h6;

  logic clk = 1'b0, rst_n = 1'b0, bus_rst = 1'b0;
  logic [3:0] cpu_addr = '0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic [NEP-1:0] ep_in_sent = '0, ep_out_rcvd = '0;
  logic [NEP*8-1:0] ep_out_count, fifo_rdata;
  logic [NEP-1:0] fifo_wr, fifo_rd, in_rdy, out_rdy;
  logic usb_en, reg_busy;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  usb_epreg_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .cpu_addr(cpu_addr),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .ep_in_sent(ep_in_sent), .ep_out_rcvd(ep_out_rcvd), .ep_out_count(ep_out_count),
    .fifo_rdata(fifo_rdata), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd), .usb_en(usb_en),
    .reg_busy(reg_busy), .in_rdy(in_rdy), .out_rdy(out_rdy)
  );

  // row: {op(1=read-expect), req, addr, data}
  localparam int NV = 34;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 4'd1,  IDX,    8'h01},  // R1 select ep1
    {1'b1, 4'd1,  IDX,    8'h01},  // R1 readback
    {1'b0, 4'd11, INMX,   8'h40},  // R11 ep1 IN max packet
    {1'b0, 4'd1,  IDX,    8'h02},  // R1
    {1'b0, 4'd11, INMX,   8'h20},  // R11 ep2
    {1'b1, 4'd11, INMX,   8'h20},  // R11
    {1'b0, 4'd1,  IDX,    8'h01},  // R1 back to ep1
    {1'b1, 4'd1,  INMX,   8'h40},  // R1 window follows index
    {1'b1, 4'd7,  WCNT,   8'h11},  // R7 count of ep1
    {1'b0, 4'd7,  WCNT,   8'hFF},  // R7 write ignored
    {1'b1, 4'd7,  WCNT,   8'h11},  // R7
    {1'b0, 4'd11, OUTMX,  8'h08},  // R11
    {1'b1, 4'd11, OUTMX,  8'h08},  // R11
    {1'b0, 4'd4,  INCSR,  8'h81},  // R4 set bit0
    {1'b1, 4'd4,  INCSR,  8'h81},  // R4
    {1'b0, 4'd4,  INCSR,  8'h00},  // R4 zero does not clear bit0
    {1'b1, 4'd4,  INCSR,  8'h01},  // R4
    {1'b0, 4'd5,  OUTCSR, 8'hFF},  // R5 one does not set bit0
    {1'b1, 4'd5,  OUTCSR, 8'hFE},  // R5
    {1'b0, 4'd1,  IDX,    8'h0F},  // R1 only 3 bits kept
    {1'b1, 4'd1,  IDX,    8'h07},  // R1
    {1'b1, 4'd2,  INMX,   8'h00},  // R2 no endpoint at 7
    {1'b0, 4'd2,  INMX,   8'h55},  // R2 write ignored
    {1'b0, 4'd2,  IDX,    8'h05},  // R2 first out-of-range value
    {1'b0, 4'd2,  INCSR,  8'h01},  // R2 write ignored
    {1'b1, 4'd2,  INCSR,  8'h00},  // R2
    {1'b1, 4'd2,  WCNT,   8'h00},  // R2
    {1'b0, 4'd2,  IDX,    8'h01},  // R2
    {1'b1, 4'd2,  INMX,   8'h40},  // R2 ep1 untouched
    {1'b0, 4'd3,  IDX,    8'h03},  // R3
    {1'b1, 4'd3,  4'h9,   8'hA1},  // R3 FIFO ep1 independent of index
    {1'b1, 4'd3,  4'hC,   8'hA4},  // R3 FIFO ep4
    {1'b0, 4'd8,  CTRL,   8'h05},  // R8
    {1'b1, 4'd8,  CTRL,   8'h05}   // R8
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); cpu_addr = a; cpu_rd = 1'b1;
    #1 chk(32'(cpu_rdata), 32'(exp), tag);
    cpu_rd = 1'b0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int e = 0; e < NEP; e++) begin
      ep_out_count[e*8 +: 8] = 8'h10 + 8'(e);
      fifo_rdata[e*8 +: 8]   = 8'hA0 + 8'(e);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state (R8, R9)
    @(negedge clk);
    chk(32'(usb_en), 0, "R8 reset usb_en");
    chk(32'(reg_busy), 0, "R10 reset busy");
    chk(32'({in_rdy, out_rdy}), 0, "R9 reset flags");
    rd_chk(IDX, 8'h00, "R9 reset index");
    rd_chk(CTRL, 8'h00, "R8 reset control");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16]) rd_chk(VEC[i][11:8], VEC[i][7:0], $sformatf("R%0d row %0d", VEC[i][15:12], i));
      else            wr(VEC[i][11:8], VEC[i][7:0]);
    end

    chk(32'(in_rdy), 32'h02, "R2 R4 only ep1 IN flag set");
    chk(32'(out_rdy), 0, "R5 no OUT flag from CPU");

    // FIFO strobes (R3), index is 3
    @(negedge clk); cpu_addr = 4'hA; cpu_wdata = 8'h5A; cpu_wr = 1'b1;
    #1 chk(32'(fifo_wr), 32'h04, "R3 fifo write strobe ep2");
    @(negedge clk); cpu_wr = 1'b0; cpu_addr = 4'h8; cpu_rd = 1'b1;
    #1 chk(32'(fifo_rd), 32'h01, "R3 fifo read strobe ep0");
    cpu_rd = 1'b0;

    // hardware clear of IN flag (R4)
    @(negedge clk); ep_in_sent = 5'b00010;
    @(negedge clk); ep_in_sent = '0;
    chk(32'(in_rdy), 0, "R4 in_sent clears");

    // OUT flag (R5)
    @(negedge clk); ep_out_rcvd = 5'b00100;
    @(negedge clk); ep_out_rcvd = '0;
    chk(32'(out_rdy), 32'h04, "R5 out_rcvd sets");
    wr(IDX, 8'h02);
    wr(OUTCSR, 8'h01);
    chk(32'(out_rdy), 32'h04, "R5 write 1 keeps");
    wr(OUTCSR, 8'h00);
    chk(32'(out_rdy), 0, "R5 write 0 clears");

    // collisions (R6)
    @(negedge clk); cpu_addr = OUTCSR; cpu_wdata = 8'h00; cpu_wr = 1'b1; ep_out_rcvd = 5'b00100;
    @(negedge clk); cpu_wr = 1'b0; ep_out_rcvd = '0;
    chk(32'(out_rdy), 32'h04, "R6 OUT event beats clear");
    @(negedge clk); cpu_addr = INCSR; cpu_wdata = 8'h01; cpu_wr = 1'b1; ep_in_sent = 5'b00100;
    @(negedge clk); cpu_wr = 1'b0; ep_in_sent = '0;
    chk(32'(in_rdy), 0, "R6 IN event beats set");

    // bus reset with controller off (R9, R8)
    wr(IDX, 8'h01);
    wr(INCSR, 8'h01);
    wr(INMX, 8'h33);
    chk(32'(in_rdy), 32'h02, "R4 ep1 set before bus reset");
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
    chk(32'({in_rdy, out_rdy}), 0, "R9 flags cleared");
    rd_chk(IDX, 8'h00, "R9 index cleared");
    wr(IDX, 8'h01);
    rd_chk(INMX, 8'h00, "R9 max packet cleared");
    rd_chk(CTRL, 8'h05, "R8 control kept");

    // enable window (R10), index is 1
    @(negedge clk); cpu_addr = CTRL; cpu_wdata = 8'h85; cpu_wr = 1'b1;         // edge E1
    @(negedge clk); cpu_wr = 1'b0;                                              // N1
    chk(32'(reg_busy), 1, "R10 busy after enable");
    chk(32'(usb_en), 1, "R8 usb_en follows bit7");
    cpu_addr = IDX; cpu_rd = 1'b1;
    #1 chk(32'(cpu_rdata), 0, "R10 read blocked");
    cpu_addr = CTRL;
    #1 chk(32'(cpu_rdata), 32'h85, "R10 control readable");
    cpu_rd = 1'b0; cpu_addr = IDX; cpu_wdata = 8'h03; cpu_wr = 1'b1;            // E2 ignored
    @(negedge clk); cpu_addr = 4'h8;                                            // N2, E3
    #1 chk(32'(fifo_wr), 0, "R10 fifo strobe blocked");
    @(negedge clk); cpu_addr = IDX; cpu_wdata = 8'h03;                          // N3, E4 ignored
    chk(32'(reg_busy), 1, "R10 busy last cycle");
    @(negedge clk); cpu_wr = 1'b0;                                              // N4
    chk(32'(reg_busy), 0, "R10 busy ends");
    cpu_rd = 1'b1;
    #1 chk(32'(cpu_rdata), 32'h01, "R10 writes in window ignored");
    cpu_rd = 1'b0; cpu_wdata = 8'h04; cpu_wr = 1'b1;                            // E5 accepted
    @(negedge clk); cpu_wr = 1'b0;
    rd_chk(IDX, 8'h04, "R10 write after window");
    wr(CTRL, 8'h85);
    chk(32'(reg_busy), 0, "R10 no restart when already on");

    // bus reset with controller on (R8)
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
    chk(32'(usb_en), 1, "R8 enable survives bus reset");

    summary();
    $finish;
  end
endmodule